// File: doc/BRIEF.md
# Round-Based 64-bit SPN Block Encryptor (80-bit key)

This block encrypts one 64-bit block under an 80-bit key with the PRESENT-80 substitution-permutation network. It completes one round in each clock cycle. The upstream logic first presents a key with a one-cycle `key_valid` strobe, and the core stores it and arms itself. A one-cycle `plain_valid` strobe then starts the encryption. The first round is computed directly on the plaintext during that same cycle. The remaining thirty rounds iterate on a 64-bit state register. The round key is derived on the fly from an 80-bit key register, which is updated once per round.

Each round mixes in the upper 64 bits of the key register by XOR. It then substitutes each 4-bit nibble through the S-box `C56B90AD3EF84712` (hex, entry 0 first) and moves bit i to position 16*i mod 63, with bit 63 kept in place. During the cycle of round 31, the core XORs that round's output with the next round key. It presents the result on `cipher_out`, together with a one-cycle `ready` pulse, and then drops back to idle. Each new encryption needs a fresh key, because the key register is consumed as the rounds proceed.

Top module: `present80_enc`

## Requirements
- R1: `rst_n` is an asynchronous, active-low reset. While it is low, and after it rises, `ready` is 0, `cipher_out` is 0 and the core is idle with no key. Asserting reset during an encryption abandons that encryption.
- R2: While idle, a `key_valid` pulse stores `key_in` and arms the core. While idle, a `plain_valid` pulse without a stored key has no effect, and no `ready` follows.
- R3: While armed, a `plain_valid` pulse starts an encryption. Round 1 is applied to `plain_in` in that same cycle, and the round counter, which starts at 1, advances.
- R4: `ready` is high for exactly one cycle. It is observed during the 30th clock cycle after the rising edge that sampled `plain_valid`, which makes 31 cycles in total including the start cycle.
- R5: `cipher_out` during `ready` equals PRESENT-80 encryption, as defined by the following parts.
  - Each round key is bits 79..16 of the key register.
  - The key update rotates the register left by 61, passes bits 79..76 through the S-box and XORs the 5-bit round number into bits 19..15.
  - After 31 rounds a final XOR with the 32nd round key is applied.
  - An all-zero key and plaintext give 5579C1387B228445 (hex).
- R6: While an encryption runs, `key_valid` and `plain_valid` pulses are ignored, and the result is unchanged.
- R7: `cipher_out` is 0 in every cycle in which `ready` is 0.
- R8: After `ready`, the core returns to idle. A `plain_valid` pulse then has no effect until a new key is loaded.
- R9: While armed, a further `key_valid` pulse on its own replaces the stored key. When `key_valid` and `plain_valid` arrive in the same armed cycle, the encryption starts with the previously stored key, and the new key is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | One-cycle strobe: `key_in` is valid |
| key_in | input | 80 | Encryption key |
| plain_valid | input | 1 | One-cycle strobe: `plain_in` is valid, start encryption |
| plain_in | input | 64 | Plaintext block |
| ready | output | 1 | One-cycle flag: `cipher_out` holds the ciphertext |
| cipher_out | output | 64 | Ciphertext, zero when `ready` is low |

## Verification
The bench drives `plain_valid` on a falling edge and takes the rising edge that follows as edge zero. It then counts falling edges and expects `ready` on exactly the 30th, with the ciphertext sampled on that same falling edge. It also expects `ready` and `cipher_out` to be back at 0 on the 31st falling edge. Strobes that should be ignored are either followed by a 40-cycle window in which `ready` must stay low, or injected partway through a run whose ciphertext must still match the known-answer value.

// File: rtl/present_pkg.sv
package present_pkg;

    localparam int BLK_W    = 64;
    localparam int KEY_W    = 80;
    localparam int NIB_W    = 4;
    localparam int CNT_W    = 5;
    localparam int LAST_RND = 31;

    // 4-bit substitution table
    function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ctrl_e;

    typedef struct packed {
        ctrl_e             st;
        logic [CNT_W-1:0]  cnt;
        logic [BLK_W-1:0]  blk;
        logic [KEY_W-1:0]  key;
    } core_regs_t;

endpackage

// File: rtl/spn_round.sv
module spn_round #(
    parameter int W     = 64,
    parameter int NIB_W = 4
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] rkey_i,
    output logic [W-1:0] state_o
);
    localparam int NIBS = W / NIB_W;

    logic [W-1:0] mixed;
    logic [W-1:0] subst;

    assign mixed = state_i ^ rkey_i;

    // substitution layer
    for (genvar n = 0; n < NIBS; n++) begin : g_sbox
        assign subst[n*NIB_W +: NIB_W] = present_pkg::sbox4(mixed[n*NIB_W +: NIB_W]);
    end

    // bit permutation: i -> i*NIBS mod (W-1), top bit fixed
    for (genvar i = 0; i < W - 1; i++) begin : g_perm
        localparam int DST = (i * NIBS) % (W - 1);
        assign state_o[DST] = subst[i];
    end
    assign state_o[W-1] = subst[W-1];

endmodule

// File: rtl/key_update.sv
module key_update #(
    parameter int KW    = 80,
    parameter int CW    = 5,
    parameter int NIB_W = 4
) (
    input  logic [KW-1:0] key_i,
    input  logic [CW-1:0] rc_i,
    output logic [KW-1:0] key_o
);
    localparam int ROT_LOW = 19;   // rotate left by KW-19
    localparam int RC_LSB  = 15;

    logic [KW-1:0] rot;

    always_comb begin
        rot   = {key_i[ROT_LOW-1:0], key_i[KW-1:ROT_LOW]};
        key_o = rot;
        key_o[KW-1 -: NIB_W]     = present_pkg::sbox4(rot[KW-1 -: NIB_W]);
        key_o[RC_LSB +: CW]      = rot[RC_LSB +: CW] ^ rc_i;
    end

endmodule

// File: rtl/present80_enc.sv
module present80_enc
    import present_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              plain_valid,
    input  logic [BLK_W-1:0]  plain_in,
    output logic              ready,
    output logic [BLK_W-1:0]  cipher_out
);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LAST_RND);
    localparam int RK_LSB = KEY_W - BLK_W;

    core_regs_t r_q, r_d;

    logic [BLK_W-1:0] rnd_in;
    logic [BLK_W-1:0] rnd_out;
    logic [KEY_W-1:0] key_nx;

    // first round reads the plaintext, later rounds the state register
    assign rnd_in = (r_q.st == ST_ARMED) ? plain_in : r_q.blk;

    spn_round #(.W(BLK_W), .NIB_W(NIB_W)) u_round (
        .state_i (rnd_in),
        .rkey_i  (r_q.key[KEY_W-1:RK_LSB]),
        .state_o (rnd_out)
    );

    key_update #(.KW(KEY_W), .CW(CNT_W), .NIB_W(NIB_W)) u_kupd (
        .key_i (r_q.key),
        .rc_i  (r_q.cnt),
        .key_o (key_nx)
    );

    always_comb begin
        r_d        = r_q;
        ready      = 1'b0;
        cipher_out = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (key_valid) begin
                    r_d.key = key_in;
                    r_d.st  = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (plain_valid) begin
                    r_d.blk = rnd_out;
                    r_d.key = key_nx;
                    r_d.cnt = r_q.cnt + CNT_FIRST;
                    r_d.st  = ST_RUN;
                end else if (key_valid) begin
                    r_d.key = key_in;
                end
            end
            ST_RUN: begin
                r_d.blk = rnd_out;
                r_d.key = key_nx;
                if (r_q.cnt == CNT_LAST) begin
                    ready      = 1'b1;
                    cipher_out = rnd_out ^ key_nx[KEY_W-1:RK_LSB];
                    r_d.cnt    = CNT_FIRST;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_FIRST;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnt = CNT_FIRST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= CNT_FIRST;
            r_q.blk <= '0;
            r_q.key <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);                                                  // R4
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (r_q.st == ST_IDLE));                                     // R8
    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && plain_valid) |=>
            (r_q.st == ST_RUN && r_q.cnt == CNT_W'(2)));                    // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt != CNT_LAST) |=>
            (r_q.st == ST_RUN && r_q.cnt == CNT_W'($past(r_q.cnt) + 1'b1))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !key_valid) |=> (r_q.st == ST_IDLE));         // R2
    AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && key_valid) |=> (r_q.key == $past(key_in)));   // R2
    AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(r_q.st == ST_RUN));                                 // R6

endmodule

// File: tb/test_present80_enc.sv
`timescale 1ns/1ps
module test_present80_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [79:0] key_in = '0;
    logic        plain_valid = 1'b0;
    logic [63:0] plain_in = '0;
    logic        ready;
    logic [63:0] cipher_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam int EXP_LAT = 30;

    always #2 clk = ~clk;   // 250 MHz

    present80_enc i_present80_enc (
        .clk(clk), .rst_n(rst_n),
        .key_valid(key_valid), .key_in(key_in),
        .plain_valid(plain_valid), .plain_in(plain_in),
        .ready(ready), .cipher_out(cipher_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_key(input logic [79:0] k);
        @(negedge clk);
        key_valid = 1'b1;
        key_in    = k;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    // start an encryption; optional same-cycle key strobe and mid-run pokes
    task automatic run_enc(input logic [63:0] pt, input bit poke,
                           input bit with_key, input logic [79:0] wk,
                           output int lat, output logic [63:0] ct);
        lat = 0;
        ct  = '0;
        @(negedge clk);
        plain_valid = 1'b1;
        plain_in    = pt;
        if (with_key) begin
            key_valid = 1'b1;
            key_in    = wk;
        end
        @(posedge clk);
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (n == 1) begin
                plain_valid = 1'b0;
                key_valid   = 1'b0;
            end
            if (poke && n == 10) begin
                key_valid   = 1'b1;
                key_in      = '1;
                plain_valid = 1'b1;
                plain_in    = '1;
            end
            if (poke && n == 11) begin
                key_valid   = 1'b0;
                plain_valid = 1'b0;
            end
            if (ready) begin
                lat = n;
                ct  = cipher_out;
                break;
            end
        end
    endtask

    task automatic t_vector(input string req, input logic [79:0] k,
                            input logic [63:0] pt, input logic [63:0] exp);
        int lat;
        logic [63:0] ct;
        load_key(k);
        run_enc(pt, 1'b0, 1'b0, '0, lat, ct);
        chk("R4", "ready latency", 64'(lat), 64'(EXP_LAT));
        chk(req, "ciphertext", ct, exp);
        @(negedge clk);
        chk("R4", "ready after pulse", {63'b0, ready}, 64'd0);
        chk("R7", "cipher_out when not ready", cipher_out, 64'd0);
    endtask

    task automatic t_quiet(input string req, input int cycles);
        bit seen = 1'b0;
        logic [63:0] ored = '0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            seen = seen | ready;
            ored = ored | cipher_out;
        end
        chk(req, "ready stays low", {63'b0, seen}, 64'd0);
        chk("R7", "cipher_out stays zero", ored, 64'd0);
    endtask

    task automatic t_plain_no_key(input string req);
        @(negedge clk);
        plain_valid = 1'b1;
        plain_in    = 64'h0123456789ABCDEF;
        @(negedge clk);
        plain_valid = 1'b0;
        t_quiet(req, 40);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R1", "ready in reset", {63'b0, ready}, 64'd0);
        chk("R1", "cipher_out in reset", cipher_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", {63'b0, ready}, 64'd0);
        chk("R7", "cipher_out after reset", cipher_out, 64'd0);
    endtask

    task automatic t_strobes_in_run;
        int lat;
        logic [63:0] ct;
        load_key('0);
        run_enc('0, 1'b1, 1'b0, '0, lat, ct);
        chk("R6", "latency with pokes", 64'(lat), 64'(EXP_LAT));
        chk("R6", "ciphertext with pokes", ct, 64'h5579C1387B228445);
    endtask

    task automatic t_rekey;
        int lat;
        logic [63:0] ct;
        load_key('1);
        load_key('0);
        run_enc('0, 1'b0, 1'b0, '0, lat, ct);
        chk("R9", "rekey ciphertext", ct, 64'h5579C1387B228445);
        load_key('0);
        run_enc('0, 1'b0, 1'b1, '1, lat, ct);
        chk("R9", "same-cycle key dropped", ct, 64'h5579C1387B228445);
    endtask

    task automatic t_reset_mid;
        int lat;
        logic [63:0] ct;
        load_key('0);
        @(negedge clk);
        plain_valid = 1'b1;
        plain_in    = '0;
        @(negedge clk);
        plain_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "ready during mid reset", {63'b0, ready}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        t_quiet("R1", 40);
        t_plain_no_key("R1");
        load_key('0);
        run_enc('0, 1'b0, 1'b0, '0, lat, ct);
        chk("R1", "run after reset", ct, 64'h5579C1387B228445);
    endtask

    initial begin
        t_reset_state();
        t_plain_no_key("R2");
        t_vector("R5", 80'h0, 64'h0, 64'h5579C1387B228445);
        t_vector("R5", 80'h0, 64'hFFFFFFFFFFFFFFFF, 64'hA112FFC72F68417B);
        t_vector("R5", {80{1'b1}}, 64'h0, 64'hE72C46C0F5945049);
        t_vector("R3", {80{1'b1}}, 64'hFFFFFFFFFFFFFFFF, 64'h3333DCD3213210D2);
        t_plain_no_key("R8");
        t_strobes_in_run();
        t_rekey();
        t_reset_mid();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule